// File: doc/BRIEF.md
# Calibration Command Controller

This block sits between a command register and two calibration engines of a readout front end. A write to the command port selects one of six calibration jobs: clock-phase tuning, pedestal/noise learning, or both, applied either to a single channel named on a select input or to every channel whose bit is set in a channel-enable mask. The block then issues work to a phase engine and a pedestal engine through request/acknowledge ports, one channel at a time, and reports the channel in progress on a status output.

Each engine port behaves like a valid/ready pair with the block as producer: a request, together with the channel number on `cal_ch`, is held until the engine returns an acknowledge, and the engine may stall for any number of cycles by keeping the acknowledge low. The command port has no back-pressure. A write accepted while a job is running is dropped, so software must wait for `busy` to fall. The run-mode flag is cleared by any calibration command and is set again only by an explicit write of command zero.

Top module: `calib_sequencer`

## Requirements
- R1: After reset `run_mode`=1 and `busy`, `done`, `cmd_err`, `phase_req`, `ped_req` and `cal_ch` are all 0.
- R2: Command 0x01 issues exactly one phase request, for channel `ch_sel`, and no pedestal request.
- R3: Command 0x02 issues exactly one pedestal request, for channel `ch_sel`, and no phase request.
- R4: Command 0x03 issues a phase request and then a pedestal request for channel `ch_sel`. The pedestal request does not start before the phase acknowledge, and the two requests are never high together.
- R5: Commands 0x10 (phase then pedestal), 0x11 (phase only) and 0x12 (pedestal only) serve every channel enabled in `ch_mask` (bit i enables channel i) in ascending channel order. The mask is captured when the command is written, and later changes to it have no effect on the running job.
- R6: Disabled channels get no request. With an all-zero mask, an all-channel command raises `busy` for one cycle and then drops it with `done`=1, issuing no request.
- R7: `cal_ch` shows the channel being served and stays stable while a request is waiting for its acknowledge.
- R8: A command code other than 0x00, 0x01, 0x02, 0x03, 0x10, 0x11 or 0x12 sets `cmd_err`, issues no request, and leaves `busy`, `done` and `run_mode` unchanged. The next accepted valid write clears `cmd_err`.
- R9: `busy` is 1 from the cycle after an accepted calibration command until the last channel completes. `done` is then set and stays set until the next accepted valid command.
- R10: `run_mode` is cleared when a calibration command is accepted, stays 0 after the job completes, and is set only by an accepted write of 0x00, which also clears `done`.
- R11: Writes made while `busy` is 1 are ignored: they do not change the job or any status output.
- R12: A request stays high until its acknowledge is sampled and falls in the cycle after that acknowledge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_wr | input | 1 | Command write strobe, one cycle per write |
| cmd_data | input | 8 | Command code |
| ch_sel | input | CH_W | Channel for single-channel commands |
| ch_mask | input | NUM_CH | Channel-enable mask for all-channel commands |
| phase_req | output | 1 | Phase engine request |
| phase_ack | input | 1 | Phase engine acknowledge |
| ped_req | output | 1 | Pedestal engine request |
| ped_ack | input | 1 | Pedestal engine acknowledge |
| cal_ch | output | CH_W | Channel currently served |
| busy | output | 1 | Job in progress |
| done | output | 1 | Last job completed |
| cmd_err | output | 1 | Last accepted write had an undefined code |
| run_mode | output | 1 | Run mode active |

## Verification
The bench logs every acknowledged request with its channel and compares the log with the list expected from the command, the captured mask and the selected channel. A wrong channel order, a skipped or extra channel, or pedestal work starting before phase work would each show up as a log mismatch. The bench targets the all-zero mask, a mask changed right after the write, writes made while busy, and undefined codes. A faulty design would hang or raise requests on an empty mask, follow the new mask, restart or drop back to run mode on a write made during a job, or start work on a bad code. Random engine stalls check that requests are held, and run-mode checks catch a design that resumes run mode on its own when a job ends.

// File: rtl/calib_pkg.sv
package calib_pkg;
  localparam int CMD_W = 8;

  localparam logic [CMD_W-1:0] OP_RUN       = 8'h00;
  localparam logic [CMD_W-1:0] OP_PH_ONE    = 8'h01;
  localparam logic [CMD_W-1:0] OP_PD_ONE    = 8'h02;
  localparam logic [CMD_W-1:0] OP_BOTH_ONE  = 8'h03;
  localparam logic [CMD_W-1:0] OP_BOTH_ALL  = 8'h10;
  localparam logic [CMD_W-1:0] OP_PH_ALL    = 8'h11;
  localparam logic [CMD_W-1:0] OP_PD_ALL    = 8'h12;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_SCAN  = 2'd1,
    ST_PHASE = 2'd2,
    ST_PED   = 2'd3
  } seq_state_t;

  typedef struct packed {
    logic valid;
    logic run;
    logic phase;
    logic ped;
    logic all;
  } cmd_dec_t;
endpackage

// File: rtl/calib_cmd_decode.sv
module calib_cmd_decode
  import calib_pkg::*;
(
  input  logic [CMD_W-1:0] code,
  output cmd_dec_t         dec
);
  always_comb begin
    dec = '0;
    unique case (code)
      OP_RUN:      begin dec.valid = 1'b1; dec.run = 1'b1; end
      OP_PH_ONE:   begin dec.valid = 1'b1; dec.phase = 1'b1; end
      OP_PD_ONE:   begin dec.valid = 1'b1; dec.ped = 1'b1; end
      OP_BOTH_ONE: begin dec.valid = 1'b1; dec.phase = 1'b1; dec.ped = 1'b1; end
      OP_BOTH_ALL: begin dec.valid = 1'b1; dec.phase = 1'b1; dec.ped = 1'b1; dec.all = 1'b1; end
      OP_PH_ALL:   begin dec.valid = 1'b1; dec.phase = 1'b1; dec.all = 1'b1; end
      OP_PD_ALL:   begin dec.valid = 1'b1; dec.ped = 1'b1; dec.all = 1'b1; end
      default:     dec = '0;
    endcase
  end
endmodule

// File: rtl/calib_first_set.sv
module calib_first_set #(
  parameter int W  = 8,
  parameter int IW = (W > 1) ? $clog2(W) : 1
) (
  input  logic [W-1:0]  vec,
  output logic          found,
  output logic [IW-1:0] idx
);
  // seen[i] is high when some bit below i is already set
  logic [W:0]   seen;
  logic [W-1:0] first;

  assign seen[0] = 1'b0;
  for (genvar g = 0; g < W; g++) begin : g_chain
    assign first[g]  = vec[g] & ~seen[g];
    assign seen[g+1] = seen[g] | vec[g];
  end

  always_comb begin
    idx = '0;
    for (int i = 0; i < W; i++) begin
      if (first[i]) idx = IW'(i);
    end
  end

  assign found = seen[W];
endmodule

// File: rtl/calib_status.sv
module calib_status (
  input  logic clk,
  input  logic rst_n,
  input  logic take_cal,
  input  logic take_run,
  input  logic take_bad,
  input  logic finish,
  output logic done,
  output logic cmd_err,
  output logic run_mode
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      done     <= 1'b0;
      cmd_err  <= 1'b0;
      run_mode <= 1'b1;
    end else begin
      if (take_bad) begin
        cmd_err <= 1'b1;
      end else if (take_cal || take_run) begin
        cmd_err <= 1'b0;
        done    <= 1'b0;
        run_mode <= take_run;
      end else if (finish) begin
        done <= 1'b1;
      end
    end
  end
endmodule

// File: rtl/calib_sequencer.sv
module calib_sequencer
  import calib_pkg::*;
#(
  parameter int NUM_CH = 8,
  localparam int CH_W = (NUM_CH > 1) ? $clog2(NUM_CH) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmd_wr,
  input  logic [CMD_W-1:0]  cmd_data,
  input  logic [CH_W-1:0]   ch_sel,
  input  logic [NUM_CH-1:0] ch_mask,
  output logic              phase_req,
  input  logic              phase_ack,
  output logic              ped_req,
  input  logic              ped_ack,
  output logic [CH_W-1:0]   cal_ch,
  output logic              busy,
  output logic              done,
  output logic              cmd_err,
  output logic              run_mode
);
  seq_state_t        state;
  cmd_dec_t          dec;
  logic [NUM_CH-1:0] pending;
  logic [NUM_CH-1:0] sel_vec;
  logic              job_phase;
  logic              job_ped;
  logic [CH_W-1:0]   cur;
  logic              nxt_found;
  logic [CH_W-1:0]   nxt_idx;
  logic              accept;
  logic              take_cal;
  logic              take_run;
  logic              take_bad;
  logic              finish;

  calib_cmd_decode u_dec (
    .code (cmd_data),
    .dec  (dec)
  );

  for (genvar g = 0; g < NUM_CH; g++) begin : g_sel
    assign sel_vec[g] = (ch_sel == CH_W'(g));
  end

  calib_first_set #(.W(NUM_CH), .IW(CH_W)) u_first (
    .vec   (pending),
    .found (nxt_found),
    .idx   (nxt_idx)
  );

  assign accept   = cmd_wr && (state == ST_IDLE);
  assign take_cal = accept && dec.valid && !dec.run;
  assign take_run = accept && dec.valid && dec.run;
  assign take_bad = accept && !dec.valid;
  assign finish   = (state == ST_SCAN) && !nxt_found;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state     <= ST_IDLE;
      pending   <= '0;
      job_phase <= 1'b0;
      job_ped   <= 1'b0;
      cur       <= '0;
    end else begin
      unique case (state)
        ST_IDLE: begin
          if (take_cal) begin
            pending   <= dec.all ? ch_mask : sel_vec;
            job_phase <= dec.phase;
            job_ped   <= dec.ped;
            state     <= ST_SCAN;
          end
        end
        ST_SCAN: begin
          if (nxt_found) begin
            cur   <= nxt_idx;
            state <= job_phase ? ST_PHASE : ST_PED;
          end else begin
            state <= ST_IDLE;
          end
        end
        ST_PHASE: begin
          if (phase_ack) begin
            if (job_ped) begin
              state <= ST_PED;
            end else begin
              pending[cur] <= 1'b0;
              state        <= ST_SCAN;
            end
          end
        end
        ST_PED: begin
          if (ped_ack) begin
            pending[cur] <= 1'b0;
            state        <= ST_SCAN;
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  calib_status u_stat (
    .clk      (clk),
    .rst_n    (rst_n),
    .take_cal (take_cal),
    .take_run (take_run),
    .take_bad (take_bad),
    .finish   (finish),
    .done     (done),
    .cmd_err  (cmd_err),
    .run_mode (run_mode)
  );

  assign phase_req = (state == ST_PHASE);
  assign ped_req   = (state == ST_PED);
  assign busy      = (state != ST_IDLE);
  assign cal_ch    = cur;
endmodule

// File: rtl/calib_sequencer_chk.sv
module calib_sequencer_chk #(
  parameter int NUM_CH = 8,
  parameter int CH_W = 3
) (
  input logic              clk,
  input logic              rst_n,
  input logic              cmd_wr,
  input logic [7:0]        cmd_data,
  input logic              phase_req,
  input logic              phase_ack,
  input logic              ped_req,
  input logic              ped_ack,
  input logic [CH_W-1:0]   cal_ch,
  input logic              busy,
  input logic              done,
  input logic              cmd_err,
  input logic              run_mode
);
  AST_REQ_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    !(phase_req && ped_req)); // R4
  AST_PHASE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    phase_req && !phase_ack |=> phase_req); // R12
  AST_PHASE_DROP: assert property (@(posedge clk) disable iff (!rst_n)
    phase_req && phase_ack |=> !phase_req); // R12
  AST_PED_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    ped_req && !ped_ack |=> ped_req); // R12
  AST_PED_DROP: assert property (@(posedge clk) disable iff (!rst_n)
    ped_req && ped_ack |=> !ped_req); // R12
  AST_CH_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
    (phase_req && !phase_ack) || (ped_req && !ped_ack) |=> $stable(cal_ch)); // R7
  AST_REQ_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    (phase_req || ped_req) |-> busy); // R9
  AST_DONE_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy); // R9
  AST_RUN_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    run_mode |-> !busy); // R10
  AST_ERR_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_err |-> !busy); // R8
  AST_RUN_SRC: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(run_mode) |-> $past(cmd_wr && cmd_data == 8'h00)); // R10
endmodule

bind calib_sequencer calib_sequencer_chk #(.NUM_CH(NUM_CH), .CH_W(CH_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .cmd_wr    (cmd_wr),
  .cmd_data  (cmd_data),
  .phase_req (phase_req),
  .phase_ack (phase_ack),
  .ped_req   (ped_req),
  .ped_ack   (ped_ack),
  .cal_ch    (cal_ch),
  .busy      (busy),
  .done      (done),
  .cmd_err   (cmd_err),
  .run_mode  (run_mode)
);

// File: tb/sim_calib_sequencer.sv
`timescale 1ns/1ps
module sim_calib_sequencer;
  localparam int NCH = 8;
  localparam int CW = 3;

  logic           clk = 1'b0;
  logic           rst_n = 1'b0;
  logic           cmd_wr = 1'b0;
  logic [7:0]     cmd_data = '0;
  logic [CW-1:0]  ch_sel = '0;
  logic [NCH-1:0] ch_mask = '0;
  logic           phase_req, ped_req, busy, done, cmd_err, run_mode;
  logic           phase_ack = 1'b0;
  logic           ped_ack = 1'b0;
  logic [CW-1:0]  cal_ch;

  int errors = 0;
  int checks = 0;
  int cycles = 0;
  int log_kind [64];
  int log_ch [64];
  int log_n = 0;
  int wait_cnt = 0;
  bit exp_run = 1'b1;
  bit exp_done = 1'b0;
  bit exp_err = 1'b0;

  always #10 clk = ~clk;

  calib_sequencer #(.NUM_CH(NCH)) u0 (
    .clk(clk), .rst_n(rst_n), .cmd_wr(cmd_wr), .cmd_data(cmd_data),
    .ch_sel(ch_sel), .ch_mask(ch_mask), .phase_req(phase_req),
    .phase_ack(phase_ack), .ped_req(ped_req), .ped_ack(ped_ack),
    .cal_ch(cal_ch), .busy(busy), .done(done), .cmd_err(cmd_err),
    .run_mode(run_mode)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic bit is_cal(input logic [7:0] c);
    return c == 8'h01 || c == 8'h02 || c == 8'h03 || c == 8'h10 || c == 8'h11 || c == 8'h12;
  endfunction

  function automatic bit does_phase(input logic [7:0] c);
    return c == 8'h01 || c == 8'h03 || c == 8'h10 || c == 8'h11;
  endfunction

  function automatic bit does_ped(input logic [7:0] c);
    return c == 8'h02 || c == 8'h03 || c == 8'h10 || c == 8'h12;
  endfunction

  // engine model: random stall, then a one-cycle acknowledge; logs each served request
  initial begin
    forever begin
      @(negedge clk);
      phase_ack = 1'b0;
      ped_ack = 1'b0;
      if (phase_req && ped_req) check(1'b0, "R4 both requests high", 1, 0);
      if (phase_req || ped_req) begin
        if (wait_cnt == 0) begin
          if (log_n < 64) begin
            log_kind[log_n] = phase_req ? 1 : 2;
            log_ch[log_n] = int'(cal_ch);
            log_n++;
          end
          if (phase_req) phase_ack = 1'b1;
          else ped_ack = 1'b1;
          wait_cnt = $urandom % 4;
        end else begin
          wait_cnt--;
        end
      end
    end
  end

  task automatic finish_run();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  initial begin
    forever begin
      @(posedge clk);
      cycles++;
      if (cycles > 150000) begin
        check(1'b0, "watchdog", cycles, 150000);
        finish_run();
      end
    end
  end

  task automatic check_status(input string req);
    check(run_mode == exp_run, {req, " run_mode"}, int'(run_mode), int'(exp_run));
    check(done == exp_done, {req, " done"}, int'(done), int'(exp_done));
    check(cmd_err == exp_err, {req, " cmd_err"}, int'(cmd_err), int'(exp_err));
  endtask

  task automatic wait_idle();
    int t = 0;
    while (busy && t < 3000) begin
      @(negedge clk);
      t++;
    end
    check(!busy, "R9 job ends", int'(busy), 0);
  endtask

  // compare the served-request log with the expected list
  task automatic check_log(input logic [7:0] c, input logic [NCH-1:0] m, input string req);
    int k = 0;
    bit ok = 1'b1;
    for (int ch = 0; ch < NCH; ch++) begin
      if (m[ch]) begin
        if (does_phase(c)) begin
          if (k >= log_n || log_kind[k] != 1 || log_ch[k] != ch) ok = 1'b0;
          k++;
        end
        if (does_ped(c)) begin
          if (k >= log_n || log_kind[k] != 2 || log_ch[k] != ch) ok = 1'b0;
          k++;
        end
      end
    end
    if (k != log_n) ok = 1'b0;
    check(ok, req, log_n, k);
  endtask

  task automatic write_cmd(input logic [7:0] c, input logic [CW-1:0] s, input logic [NCH-1:0] m);
    @(negedge clk);
    log_n = 0;
    cmd_wr = 1'b1;
    cmd_data = c;
    ch_sel = s;
    ch_mask = m;
    @(negedge clk);
    cmd_wr = 1'b0;
    ch_mask = NCH'($urandom); // R5: mask changed after capture
  endtask

  task automatic run_cmd(input logic [7:0] c, input logic [CW-1:0] s, input logic [NCH-1:0] m);
    logic [NCH-1:0] eff;
    bool_all: begin end
    eff = (c[4]) ? m : NCH'(1) << s;
    write_cmd(c, s, m);
    if (is_cal(c)) begin
      check(busy == 1'b1, "R9 busy after accept", int'(busy), 1);
      check(run_mode == 1'b0, "R10 run_mode cleared", int'(run_mode), 0);
      wait_idle();
      exp_run = 1'b0; exp_done = 1'b1; exp_err = 1'b0;
      check_status("R9 R10 after job");
      case (c)
        8'h01: check_log(c, eff, "R2 phase single log");
        8'h02: check_log(c, eff, "R3 pedestal single log");
        8'h03: check_log(c, eff, "R4 full single log");
        default: check_log(c, eff, "R5 R6 all-channel log");
      endcase
    end else if (c == 8'h00) begin
      exp_run = 1'b1; exp_done = 1'b0; exp_err = 1'b0;
      check(busy == 1'b0, "R10 run write idle", int'(busy), 0);
      check_status("R10 run write");
    end else begin
      exp_err = 1'b1;
      check(busy == 1'b0, "R8 bad code no busy", int'(busy), 0);
      check_status("R8 bad code");
      repeat (3) @(negedge clk);
      check(log_n == 0, "R8 bad code no request", log_n, 0);
    end
  endtask

  initial begin
    logic [7:0] pick [8];
    pick = '{8'h01, 8'h02, 8'h03, 8'h10, 8'h11, 8'h12, 8'h00, 8'h07};
    void'($urandom(32'h00C0FFEE));
    repeat (3) @(negedge clk);
    // R1 reset state
    check(run_mode == 1'b1 && !busy && !done && !cmd_err, "R1 reset status", int'(run_mode), 1);
    check(!phase_req && !ped_req && cal_ch == '0, "R1 reset outputs", int'(phase_req), 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);

    // directed single-channel commands
    run_cmd(8'h01, 3'd5, '0);
    run_cmd(8'h02, 3'd0, '0);
    run_cmd(8'h03, 3'd7, '0);
    // R10: stays out of run mode until command 0
    repeat (5) @(negedge clk);
    check(run_mode == 1'b0, "R10 no auto resume", int'(run_mode), 0);
    run_cmd(8'h00, 3'd0, '0);

    // all-channel commands
    run_cmd(8'h10, 3'd0, 8'hFF);
    run_cmd(8'h11, 3'd0, 8'hA5);
    run_cmd(8'h12, 3'd0, 8'h81);

    // R6 empty mask: busy one cycle, then done
    write_cmd(8'h10, 3'd2, 8'h00);
    check(busy == 1'b1, "R6 empty mask busy", int'(busy), 1);
    @(negedge clk);
    check(!busy && done, "R6 empty mask done", int'(done), 1);
    check(log_n == 0, "R6 empty mask no request", log_n, 0);
    exp_run = 1'b0; exp_done = 1'b1; exp_err = 1'b0;

    // R8 undefined codes keep done and run_mode
    run_cmd(8'h04, 3'd1, 8'hFF);
    run_cmd(8'hFF, 3'd1, 8'hFF);
    run_cmd(8'h02, 3'd4, '0); // R8 error cleared by valid write

    // R11 writes during a job are ignored
    write_cmd(8'h10, 3'd0, 8'hFF);
    cmd_wr = 1'b1; cmd_data = 8'h02; ch_sel = 3'd3;
    @(negedge clk);
    cmd_data = 8'h00;
    @(negedge clk);
    cmd_data = 8'h55;
    @(negedge clk);
    cmd_wr = 1'b0;
    check(busy && !run_mode && !cmd_err, "R11 write during job", int'(run_mode), 0);
    wait_idle();
    exp_run = 1'b0; exp_done = 1'b1; exp_err = 1'b0;
    check_status("R11 after job");
    check_log(8'h10, 8'hFF, "R11 job unchanged");

    // random mix
    for (int i = 0; i < 60; i++) begin
      logic [7:0] c;
      c = pick[$urandom % 8];
      if (c == 8'h07) c = 8'h20 | 8'($urandom % 8'hDF);
      run_cmd(c, CW'($urandom), NCH'($urandom));
    end

    finish_run();
  end
endmodule